// File: doc/BRIEF.md
# Scripted Debug Message Sequencer

This block is the host side of an on-chip debug link, driven from a stored script instead of an interactive host. Before a session, a script of command messages is written into its script store, one entry per word. A start pulse makes the sequencer walk the store from address 0 and put each ordinary entry on the outgoing message bus toward the debug port. Three header codes are reserved and never leave the block. One pauses for a programmed number of cycles. One stalls until the target's event pin goes high. One marks the end of the script.

Every message the debug port returns is captured in a separate log store in arrival order, whatever the sequencer is doing. After the session the log is read back through a read port for offline analysis. When the log is full, later messages are dropped and a sticky flag records the loss. The block runs entirely on the debug-link clock. The event pin comes from the target clock domain and passes through a synchronizer.

Top module: `dbg_script_seq`

## Requirements
- R1: After reset, busy, done, tx_valid and log_ovf are low and log_count is 0.
- R2: A start pulse while neither busy nor running sends the script from address 0 in order. Each entry whose header (bits [21:16]; the data field is bits [15:0]) is not reserved appears once on tx_msg, unchanged, with tx_valid high for one cycle. Consecutive ordinary entries go out on consecutive cycles.
- R3: Header 6'h3D is a pause entry and is never sent. If ordinary messages come before and after a pause with data field N, exactly N+2 idle cycles separate them.
- R4: Header 6'h3E is a wait entry and is never sent. Nothing is sent while evt_in stays low. When evt_in goes high, the next message appears on the 4th rising clock edge after the change.
- R5: Header 6'h3F ends the script. Running past the last script address also ends it. At the end, done goes high, busy goes low, and nothing more is sent until the next start. The end entry is never sent.
- R6: Each cycle with rx_valid high stores rx_msg at the next log address, starting from 0. log_count gives the number of stored entries, and log_rdata shows the entry at log_raddr combinationally.
- R7: With LOG_DEPTH entries stored, further received messages are dropped and stored entries stay unchanged. log_count stays at LOG_DEPTH, and log_ovf rises and stays high until the next accepted start.
- R8: An accepted start clears log_count and log_ovf. A start while busy is ignored: the log is kept and the script carries on.
- R9: If a message arrives in the same cycle as an accepted start, it is stored at address 0 and log_count becomes 1.
- R10: Logging does not depend on the sequencer. Messages received in the cycles where messages are being sent are all stored in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Debug-link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start a session (accepted when not busy) |
| busy | output | 1 | Script is running, pausing or waiting |
| done | output | 1 | Script finished; held until the next start |
| ld_en | input | 1 | Write enable for the script store |
| ld_addr | input | 4 | Script store write address |
| ld_data | input | 22 | Script entry: header [21:16], data [15:0] |
| evt_in | input | 1 | Target event pin (asynchronous) |
| tx_valid | output | 1 | Outgoing message valid for this cycle |
| tx_msg | output | 22 | Outgoing message toward the debug port |
| rx_valid | input | 1 | Incoming message valid this cycle |
| rx_msg | input | 22 | Incoming message from the debug port |
| log_raddr | input | 3 | Log store read address |
| log_rdata | output | 22 | Log entry at log_raddr |
| log_count | output | 4 | Number of stored log entries |
| log_ovf | output | 1 | Sticky log overflow flag |

## Verification
Two functions can land on the same clock edge: a session start, which clears the log, and a returned message being logged. The bench drives start and rx_valid in the same cycle from the done state, after it has forced an overflow. It then expects the message at log slot 0, a count of one and a cleared overflow flag. Sending and logging can also coincide. Messages are injected while the script is streaming, and both the transmitted order and the log contents are judged against the script and the injected data.

// File: rtl/seq_pkg.sv
`timescale 1ns/1ps
package seq_pkg;
  localparam int HDR_W = 6;
  localparam logic [HDR_W-1:0] HDR_PAUSE = 6'h3D;
  localparam logic [HDR_W-1:0] HDR_WAIT  = 6'h3E;
  localparam logic [HDR_W-1:0] HDR_END   = 6'h3F;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_PAUSE,
    ST_WAIT,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/seq_regfile.sv
`timescale 1ns/1ps
module seq_regfile #(
  parameter int W     = 22,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    logic row_en;
    assign row_en = we && (waddr == AW'(i));
    always_ff @(posedge clk) begin
      if (row_en) mem[i] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/seq_sync.sv
`timescale 1ns/1ps
module seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/seq_ctrl.sv
`timescale 1ns/1ps
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int SCRIPT_DEPTH = 16,
  localparam int ENT_W       = HDR_W + DATA_W,
  localparam int SA_W        = $clog2(SCRIPT_DEPTH),
  localparam int PC_W        = SA_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             evt_s,
  input  logic [ENT_W-1:0] ent,
  output logic [SA_W-1:0]  rd_addr,
  output logic             start_acc,
  output logic             busy,
  output logic             done,
  output logic             tx_valid,
  output logic [ENT_W-1:0] tx_msg
);
  localparam logic [PC_W-1:0] PC_END = PC_W'(SCRIPT_DEPTH);

  seq_state_e        state_q, state_n;
  logic [PC_W-1:0]   pc_q, pc_n;
  logic              pc_en;
  logic [DATA_W-1:0] dcnt_q, dcnt_n;
  logic              dcnt_en;
  logic              txv_q, txv_n;
  logic              tx_load;
  logic [ENT_W-1:0]  txm_q;

  logic [HDR_W-1:0]  hdr;
  logic [DATA_W-1:0] fld;
  logic              at_end;

  assign hdr     = ent[ENT_W-1:DATA_W];
  assign fld     = ent[DATA_W-1:0];
  assign at_end  = (pc_q == PC_END);
  assign rd_addr = pc_q[SA_W-1:0];

  assign busy      = (state_q == ST_RUN) || (state_q == ST_PAUSE) || (state_q == ST_WAIT);
  assign done      = (state_q == ST_DONE);
  assign start_acc = start && !busy;

  // next-state logic
  always_comb begin
    state_n = state_q;
    pc_n    = pc_q;
    pc_en   = 1'b0;
    dcnt_n  = dcnt_q;
    dcnt_en = 1'b0;
    txv_n   = 1'b0;
    tx_load = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          state_n = ST_RUN;
          pc_n    = '0;
          pc_en   = 1'b1;
        end
      end
      ST_RUN: begin
        if (at_end) begin
          state_n = ST_DONE;
        end else begin
          pc_n  = pc_q + PC_W'(1);
          pc_en = 1'b1;
          if (hdr == HDR_END) begin
            state_n = ST_DONE;
            pc_en   = 1'b0;
          end else if (hdr == HDR_PAUSE) begin
            state_n = ST_PAUSE;
            dcnt_n  = fld;
            dcnt_en = 1'b1;
          end else if (hdr == HDR_WAIT) begin
            state_n = ST_WAIT;
          end else begin
            txv_n   = 1'b1;
            tx_load = 1'b1;
          end
        end
      end
      ST_PAUSE: begin
        if (dcnt_q == '0) begin
          state_n = ST_RUN;
        end else begin
          dcnt_n  = dcnt_q - DATA_W'(1);
          dcnt_en = 1'b1;
        end
      end
      ST_WAIT: begin
        if (evt_s) state_n = ST_RUN;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      dcnt_q  <= '0;
      txv_q   <= 1'b0;
      txm_q   <= '0;
    end else begin
      state_q <= state_n;
      txv_q   <= txv_n;
      if (pc_en)   pc_q   <= pc_n;
      if (dcnt_en) dcnt_q <= dcnt_n;
      if (tx_load) txm_q  <= ent;
    end
  end

  assign tx_valid = txv_q;
  assign tx_msg   = txm_q;
endmodule

// File: rtl/seq_log.sv
`timescale 1ns/1ps
module seq_log #(
  parameter int ENT_W     = 22,
  parameter int LOG_DEPTH = 8,
  localparam int LA_W     = $clog2(LOG_DEPTH),
  localparam int CNT_W    = LA_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             rx_valid,
  input  logic [ENT_W-1:0] rx_msg,
  input  logic [LA_W-1:0]  raddr,
  output logic [ENT_W-1:0] rdata,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(LOG_DEPTH);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;
  logic             ovf_q, ovf_n;
  logic             ovf_en;
  logic             full;
  logic             wr_en;
  logic [LA_W-1:0]  wr_addr;

  assign full    = (cnt_q == FULL);
  assign wr_en   = rx_valid && (clr || !full);
  assign wr_addr = clr ? '0 : cnt_q[LA_W-1:0];

  always_comb begin
    cnt_n  = cnt_q;
    cnt_en = 1'b0;
    ovf_n  = ovf_q;
    ovf_en = 1'b0;
    if (clr) begin
      cnt_n  = rx_valid ? CNT_W'(1) : '0;
      cnt_en = 1'b1;
      ovf_n  = 1'b0;
      ovf_en = 1'b1;
    end else if (rx_valid) begin
      if (full) begin
        ovf_n  = 1'b1;
        ovf_en = 1'b1;
      end else begin
        cnt_n  = cnt_q + CNT_W'(1);
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_n;
      if (ovf_en) ovf_q <= ovf_n;
    end
  end

  seq_regfile #(.W(ENT_W), .DEPTH(LOG_DEPTH)) u_mem (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (rx_msg),
    .raddr (raddr),
    .rdata (rdata)
  );

  assign count = cnt_q;
  assign ovf   = ovf_q;
endmodule

// File: rtl/dbg_script_seq.sv
`timescale 1ns/1ps
module dbg_script_seq
  import seq_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int SCRIPT_DEPTH = 16,
  parameter int LOG_DEPTH    = 8,
  parameter int SYNC_STAGES  = 2,
  localparam int ENT_W       = HDR_W + DATA_W,
  localparam int SA_W        = $clog2(SCRIPT_DEPTH),
  localparam int LA_W        = $clog2(LOG_DEPTH),
  localparam int CNT_W       = LA_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  input  logic             ld_en,
  input  logic [SA_W-1:0]  ld_addr,
  input  logic [ENT_W-1:0] ld_data,
  input  logic             evt_in,
  output logic             tx_valid,
  output logic [ENT_W-1:0] tx_msg,
  input  logic             rx_valid,
  input  logic [ENT_W-1:0] rx_msg,
  input  logic [LA_W-1:0]  log_raddr,
  output logic [ENT_W-1:0] log_rdata,
  output logic [CNT_W-1:0] log_count,
  output logic             log_ovf
);
  logic [SA_W-1:0]  scr_raddr;
  logic [ENT_W-1:0] scr_ent;
  logic             evt_s;
  logic             start_acc;

  seq_regfile #(.W(ENT_W), .DEPTH(SCRIPT_DEPTH)) u_script (
    .clk   (clk),
    .we    (ld_en),
    .waddr (ld_addr),
    .wdata (ld_data),
    .raddr (scr_raddr),
    .rdata (scr_ent)
  );

  seq_sync #(.STAGES(SYNC_STAGES)) u_evt_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (evt_in),
    .q     (evt_s)
  );

  seq_ctrl #(.DATA_W(DATA_W), .SCRIPT_DEPTH(SCRIPT_DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .evt_s     (evt_s),
    .ent       (scr_ent),
    .rd_addr   (scr_raddr),
    .start_acc (start_acc),
    .busy      (busy),
    .done      (done),
    .tx_valid  (tx_valid),
    .tx_msg    (tx_msg)
  );

  seq_log #(.ENT_W(ENT_W), .LOG_DEPTH(LOG_DEPTH)) u_log (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start_acc),
    .rx_valid (rx_valid),
    .rx_msg   (rx_msg),
    .raddr    (log_raddr),
    .rdata    (log_rdata),
    .count    (log_count),
    .ovf      (log_ovf)
  );
endmodule

// File: rtl/seq_chk.sv
`timescale 1ns/1ps
module seq_chk
  import seq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int LOG_DEPTH = 8,
  localparam int ENT_W    = HDR_W + DATA_W,
  localparam int CNT_W    = $clog2(LOG_DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             tx_valid,
  input logic [ENT_W-1:0] tx_msg,
  input logic             rx_valid,
  input logic [CNT_W-1:0] log_count,
  input logic             log_ovf
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(LOG_DEPTH);
  logic [HDR_W-1:0] tx_hdr;
  assign tx_hdr = tx_msg[ENT_W-1:DATA_W];

  a_r2_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !tx_valid);

  a_r3_pause_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_hdr != HDR_PAUSE);

  a_r4_wait_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_hdr != HDR_WAIT);

  a_r5_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!tx_valid && !busy && tx_hdr != HDR_END));

  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    log_count <= FULL);

  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (log_ovf && !(start && !busy)) |=> log_ovf);

  a_r8_busy_start_keeps_log: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !rx_valid) |=> $stable(log_count));

  a_r9_start_with_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && rx_valid) |=> (log_count == CNT_W'(1) && !log_ovf));
endmodule

bind dbg_script_seq seq_chk #(.DATA_W(DATA_W), .LOG_DEPTH(LOG_DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .tx_valid  (tx_valid),
  .tx_msg    (tx_msg),
  .rx_valid  (rx_valid),
  .log_count (log_count),
  .log_ovf   (log_ovf)
);

// File: tb/test_dbg_script_seq.sv
`timescale 1ns/1ps
module test_dbg_script_seq;
  localparam int ENT_W = 22;

  logic clk, rst_n, start, busy, done, ld_en, evt_in, tx_valid, rx_valid, log_ovf;
  logic [3:0]       ld_addr;
  logic [ENT_W-1:0] ld_data, tx_msg, rx_msg, log_rdata;
  logic [2:0]       log_raddr;
  logic [3:0]       log_count;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int mon_n = 0;
  logic [ENT_W-1:0] mon_msg [64];
  int               mon_cyc [64];
  bit               finished = 0;

  dbg_script_seq i_dbg_script_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data), .evt_in(evt_in),
    .tx_valid(tx_valid), .tx_msg(tx_msg), .rx_valid(rx_valid), .rx_msg(rx_msg),
    .log_raddr(log_raddr), .log_rdata(log_rdata), .log_count(log_count),
    .log_ovf(log_ovf)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (tx_valid && mon_n < 64) begin
      mon_msg[mon_n] <= tx_msg;
      mon_cyc[mon_n] <= cyc;
      mon_n <= mon_n + 1;
    end
  end

  function automatic logic [ENT_W-1:0] mk(input logic [5:0] h, input logic [15:0] d);
    return {h, d};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input int a, input logic [ENT_W-1:0] e);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = 4'(a); ld_data = e;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 200; i++) begin
      if (done) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic rx(input logic [ENT_W-1:0] m);
    @(negedge clk); rx_valid = 1'b1; rx_msg = m;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic read_log(input int a, output logic [ENT_W-1:0] v);
    @(negedge clk); log_raddr = 3'(a);
    #1 v = log_rdata;
  endtask

  task automatic t_reset();
    chk(!busy && !done && !tx_valid, "R1 ctrl idle", {busy, done, tx_valid}, 0);
    chk(log_count == 0 && !log_ovf, "R1 log empty", {log_count, log_ovf}, 0);
  endtask

  task automatic t_stream();
    int b;
    for (int i = 0; i < 4; i++) load(i, mk(6'(i + 1), 16'(16'h1110 * (i + 1))));
    load(4, mk(6'h3F, 16'h0));
    b = mon_n;
    pulse_start();
    wait_done();
    chk(mon_n - b == 4, "R2 count", mon_n - b, 4);
    for (int i = 0; i < 4; i++)
      chk(mon_msg[b+i] == mk(6'(i + 1), 16'(16'h1110 * (i + 1))), "R2 order", mon_msg[b+i], mk(6'(i + 1), 16'(16'h1110 * (i + 1))));
    chk(mon_cyc[b+3] - mon_cyc[b] == 3, "R2 back to back", mon_cyc[b+3] - mon_cyc[b], 3);
    chk(done && !busy, "R5 end entry", {done, busy}, 2'b10);
  endtask

  task automatic t_pause();
    int b;
    load(0, mk(6'h0A, 16'hAAAA));
    load(1, mk(6'h3D, 16'd5));
    load(2, mk(6'h0B, 16'hBBBB));
    load(3, mk(6'h3D, 16'd0));
    load(4, mk(6'h0C, 16'hCCCC));
    load(5, mk(6'h3F, 16'h0));
    b = mon_n;
    pulse_start();
    wait_done();
    chk(mon_n - b == 3, "R3 pause not sent", mon_n - b, 3);
    chk(mon_msg[b+1] == mk(6'h0B, 16'hBBBB), "R3 next msg", mon_msg[b+1], mk(6'h0B, 16'hBBBB));
    chk(mon_cyc[b+1] - mon_cyc[b] == 8, "R3 pause 5 gap", mon_cyc[b+1] - mon_cyc[b], 8);
    chk(mon_cyc[b+2] - mon_cyc[b+1] == 3, "R3 pause 0 gap", mon_cyc[b+2] - mon_cyc[b+1], 3);
  endtask

  task automatic t_wait();
    int b, seen;
    load(0, mk(6'h01, 16'h0001));
    load(1, mk(6'h3E, 16'h0));
    load(2, mk(6'h02, 16'h0002));
    load(3, mk(6'h3F, 16'h0));
    b = mon_n;
    pulse_start();
    repeat (20) @(negedge clk);
    chk(mon_n - b == 1, "R4 stalled", mon_n - b, 1);
    chk(busy && !done, "R4 still busy", {busy, done}, 2'b10);
    evt_in = 1'b1;
    seen = 0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (tx_valid && seen == 0) seen = i;
    end
    evt_in = 1'b0;
    chk(seen == 4, "R4 release latency", seen, 4);
    wait_done();
    chk(mon_n - b == 2 && mon_msg[b+1] == mk(6'h02, 16'h0002), "R4 msg after wait", mon_msg[b+1], mk(6'h02, 16'h0002));
  endtask

  task automatic t_endmem();
    int b;
    for (int i = 0; i < 16; i++) load(i, mk(6'(i + 1), 16'(i)));
    b = mon_n;
    pulse_start();
    wait_done();
    chk(mon_n - b == 16, "R5 ran off end", mon_n - b, 16);
    chk(mon_msg[b+15] == mk(6'd16, 16'd15), "R5 last entry", mon_msg[b+15], mk(6'd16, 16'd15));
    repeat (5) @(negedge clk);
    chk(mon_n - b == 16 && done, "R5 silent after end", mon_n - b, 16);
  endtask

  task automatic t_log_concurrent();
    logic [ENT_W-1:0] v;
    int b;
    for (int i = 0; i < 4; i++) load(i, mk(6'h05, 16'(i)));
    load(4, mk(6'h3F, 16'h0));
    b = mon_n;
    pulse_start();
    rx_valid = 1'b1; rx_msg = mk(6'h21, 16'h0101);
    @(negedge clk); rx_msg = mk(6'h22, 16'h0202);
    @(negedge clk); rx_msg = mk(6'h23, 16'h0303);
    @(negedge clk); rx_valid = 1'b0;
    wait_done();
    chk(mon_n - b == 4, "R10 tx during rx", mon_n - b, 4);
    chk(log_count == 3, "R6 count", log_count, 3);
    for (int i = 0; i < 3; i++) begin
      read_log(i, v);
      chk(v == mk(6'(6'h21 + i), 16'(16'h0101 * (i + 1))), "R10 log order", v, mk(6'(6'h21 + i), 16'(16'h0101 * (i + 1))));
    end
  endtask

  task automatic t_overflow();
    logic [ENT_W-1:0] v;
    load(0, mk(6'h3F, 16'h0));
    pulse_start();
    wait_done();
    chk(log_count == 0, "R8 start clears", log_count, 0);
    for (int i = 0; i < 10; i++) rx(mk(6'h30, 16'(i)));
    chk(log_count == 8, "R7 count saturates", log_count, 8);
    chk(log_ovf, "R7 overflow set", log_ovf, 1);
    read_log(7, v);
    chk(v == mk(6'h30, 16'd7), "R7 last kept", v, mk(6'h30, 16'd7));
    read_log(0, v);
    chk(v == mk(6'h30, 16'd0), "R6 first kept", v, mk(6'h30, 16'd0));
    repeat (4) @(negedge clk);
    chk(log_ovf, "R7 sticky", log_ovf, 1);
  endtask

  task automatic t_start_rx();
    logic [ENT_W-1:0] v;
    @(negedge clk);
    start = 1'b1; rx_valid = 1'b1; rx_msg = mk(6'h2A, 16'h5A5A);
    @(negedge clk);
    start = 1'b0; rx_valid = 1'b0;
    chk(log_count == 1, "R9 count", log_count, 1);
    chk(!log_ovf, "R9 ovf cleared", log_ovf, 0);
    read_log(0, v);
    chk(v == mk(6'h2A, 16'h5A5A), "R9 slot0", v, mk(6'h2A, 16'h5A5A));
    wait_done();
  endtask

  task automatic t_start_busy();
    int b;
    load(0, mk(6'h3E, 16'h0));
    load(1, mk(6'h07, 16'h7777));
    load(2, mk(6'h3F, 16'h0));
    b = mon_n;
    pulse_start();
    rx(mk(6'h11, 16'h1));
    rx(mk(6'h12, 16'h2));
    chk(log_count == 2, "R8 logged in wait", log_count, 2);
    pulse_start();
    repeat (3) @(negedge clk);
    chk(log_count == 2 && busy, "R8 busy start ignored", log_count, 2);
    evt_in = 1'b1;
    repeat (3) @(negedge clk);
    evt_in = 1'b0;
    wait_done();
    chk(mon_n - b == 1 && mon_msg[b] == mk(6'h07, 16'h7777), "R8 script kept going", mon_n - b, 1);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; ld_en = 1'b0; ld_addr = '0; ld_data = '0;
    evt_in = 1'b0; rx_valid = 1'b0; rx_msg = '0; log_raddr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stream();
    t_pause();
    t_wait();
    t_endmem();
    t_log_concurrent();
    t_overflow();
    t_start_rx();
    t_start_busy();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule